// File: doc/BRIEF.md
# Rail Fault and Power-Good Supervisor

This block watches the health of a power-switching controller that feeds four output rails from either main or standby supplies. It takes digital flags from external comparators: one undervoltage flag per output rail (set when the rail sits below 80% of its nominal level), one enable per rail, a low-voltage flag for each of the two input supplies (standby and 12 V), a die over-temperature flag, and the current sleep state. From these it produces a shutdown request that turns every output off, and a power-good output.

The block separates two kinds of fault. A rail undervoltage is treated as an overcurrent: it must persist for a programmable number of consecutive clock cycles before a latch sets. Once set, the latch holds shutdown until the standby power-on reset clears it. Over-temperature and input undervoltage lockout are self-clearing: they force shutdown only while their flag is present. Rails that are deliberately off are not monitored: a rail whose enable is low, and the memory rails in the deepest sleep state. Power-good drops at once on any monitored undervoltage, without waiting for the trip delay.

Top module: `rail_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, `shutdown` is 1 and `pwr_good` is 0; after release with every flag clear, `shutdown` is 0 and `pwr_good` is 1.
- R2: A monitored rail whose `rail_uv` bit is 1 at `TRIP_CYCLES` consecutive rising clock edges sets the fault latch at the last of those edges, which raises `shutdown`; `TRIP_CYCLES-1` edges do not set it.
- R3: Once set, the fault latch keeps `shutdown` at 1 whatever the other inputs do, until `rst_n` goes low.
- R4: When `pwr_state` equals 2'b10 (deepest sleep), rails marked in `MEM_RAILS` (default bits 2 and 3) are not monitored: their undervoltage neither trips the latch nor lowers `pwr_good`. State codes 2'b00 and 2'b01 monitor all enabled rails.
- R5: `over_temp` = 1 drives `shutdown` to 1 in the same cycle, and `shutdown` returns to 0 as soon as it clears; it never sets the latch.
- R6: `stby_low` = 1 or `main12_low` = 1 drives `shutdown` to 1 in the same cycle and returns with the flag; while any of these or `over_temp` is set, rail undervoltage does not advance toward a trip.
- R7: `pwr_good` is 0 in the same cycle that any monitored rail has its `rail_uv` bit at 1, before any trip.
- R8: The trip count restarts from zero whenever a rail's monitored undervoltage is absent at a clock edge, so separate bursts shorter than `TRIP_CYCLES` never trip.
- R9: A rail whose `rail_en` bit is 0 is not monitored: its undervoltage neither trips the latch nor lowers `pwr_good`.
- R10: `pwr_good` is 0 whenever `shutdown` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Standby power-on reset, active low; the only clear for the fault latch |
| rail_uv | input | N_RAILS | Per-rail flag, 1 when the rail is below 80% of nominal |
| rail_en | input | N_RAILS | Per-rail enable, 1 when the rail is meant to be on |
| pwr_state | input | 2 | Sleep state: 2'b00 full power, 2'b01 suspend, 2'b10 deepest sleep |
| stby_low | input | 1 | Standby supply below its lockout threshold |
| main12_low | input | 1 | 12 V supply below its lockout threshold |
| over_temp | input | 1 | Die over-temperature flag |
| shutdown | output | 1 | 1 requests all outputs off |
| pwr_good | output | 1 | 1 when all monitored rails are valid and no shutdown is active |

## Verification
A trip counter stuck, skipping or failing to restart shows at the ports as `shutdown` rising one or more edges early or late against the exact count of consecutive undervoltage edges, so the bench counts edges and samples right after the expected one. A latch that clears by itself shows as `shutdown` falling after all flags clear, visible within a few cycles; a wrong mask (enable or deepest-sleep memory rails) shows immediately as `pwr_good` low, and after the trip delay as a spurious shutdown. The sweep covers every rail, every state code and both enable values, so a mis-indexed mask surfaces on the rail it affects.

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int N_RAILS = 4,
  parameter logic [N_RAILS-1:0] MEM_RAILS = 4'b1100,
  parameter int TRIP_CYCLES = 37500,
  parameter logic [1:0] DEEP_SLEEP = 2'b10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_uv,
  input  logic [N_RAILS-1:0] rail_en,
  input  logic [1:0]         pwr_state,
  input  logic               stby_low,
  input  logic               main12_low,
  input  logic               over_temp,
  output logic               shutdown,
  output logic               pwr_good
);

  localparam int CW = $clog2(TRIP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIP_CYCLES - 1);

  logic               in_deep;
  logic               hold;
  logic [N_RAILS-1:0] watch;
  logic [N_RAILS-1:0] mon;
  logic [N_RAILS-1:0] expire;
  logic               trip_q;

  assign in_deep = (pwr_state == DEEP_SLEEP);
  assign hold    = stby_low | main12_low | over_temp;
  assign watch   = rail_en & ~(MEM_RAILS & {N_RAILS{in_deep}});
  assign mon     = rail_uv & watch;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (!mon[i] || hold)
        cnt <= '0;
      else if (cnt != LAST)
        cnt <= cnt + CW'(1);
    end

    assign expire[i] = mon[i] & ~hold & (cnt == LAST);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon[i] || hold) |=> (cnt == '0)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R2
    if (MEM_RAILS[i]) begin : g_mem
      AST_DEEP_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_deep |=> (cnt == '0)); // R4
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trip_q <= 1'b0;
    else if (|expire)
      trip_q <= 1'b1;
  end

  assign shutdown = ~rst_n | trip_q | hold;
  assign pwr_good = ~shutdown & ~|mon;

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> trip_q); // R3
  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past((|mon) && !hold)); // R2

endmodule

// File: tb/test_rail_fault_supervisor.sv
module test_rail_fault_supervisor;
  localparam int N = 4;
  localparam int T = 6;
  localparam logic [N-1:0] MEM = 4'b1100;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] rail_uv = '0;
  logic [N-1:0] rail_en = '1;
  logic [1:0] pwr_state = 2'b00;
  logic stby_low = 0, main12_low = 0, over_temp = 0;
  logic shutdown, pwr_good;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  rail_fault_supervisor #(.N_RAILS(N), .MEM_RAILS(MEM), .TRIP_CYCLES(T)) i_rail_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .rail_uv(rail_uv), .rail_en(rail_en), .pwr_state(pwr_state),
    .stby_low(stby_low), .main12_low(main12_low), .over_temp(over_temp),
    .shutdown(shutdown), .pwr_good(pwr_good));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    rail_uv = '0; rail_en = '1; pwr_state = 2'b00;
    stby_low = 0; main12_low = 0; over_temp = 0;
    #1;
    chk("R1 shutdown in reset", shutdown, 1'b1);
    chk("R1 pwr_good in reset", pwr_good, 1'b0);
    edges(2);
    rst_n = 1;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 shutdown after release", shutdown, 1'b0);
    chk("R1 pwr_good after release", pwr_good, 1'b1);

    // Sweep: every rail, state code and enable value (R2 R4 R7 R9)
    for (int r = 0; r < N; r++)
      for (int s = 0; s < 3; s++)
        for (int e = 0; e < 2; e++) begin
          logic watched;
          watched = (e == 1) && !(MEM[r] && s == 2);
          do_reset();
          @(negedge clk);
          pwr_state = 2'(s);
          rail_en = '1;
          rail_en[r] = 1'(e);
          rail_uv = '0;
          rail_uv[r] = 1'b1;
          #1;
          chk(watched ? "R7 pwr_good on uv" : (e == 0 ? "R9 masked pwr_good" : "R4 deep mem pwr_good"),
              pwr_good, !watched);
          edges(T - 1);
          chk("R2 no trip at T-1", shutdown, 1'b0);
          repeat (1) @(posedge clk);
          @(negedge clk);
          rail_uv = '0;
          #1;
          chk(watched ? "R2 trip at T" : (e == 0 ? "R9 masked no trip" : "R4 deep mem no trip"),
              shutdown, watched);
          chk("R10 pwr_good vs shutdown", pwr_good, !watched);
          edges(20);
          chk("R3 latch holds", shutdown, watched);
        end

    // R8: broken bursts never trip
    do_reset();
    @(negedge clk);
    rail_uv = 4'b0001;
    edges(T - 1);
    rail_uv = 4'b0000;
    edges(1);
    rail_uv = 4'b0001;
    edges(T - 1);
    #1;
    chk("R8 restart after gap", shutdown, 1'b0);
    edges(1);
    #1;
    chk("R8 trip after full run", shutdown, 1'b1);
    rail_uv = '0;
    do_reset();
    chk("R3 reset clears latch", shutdown, 1'b0);

    // R5: over-temperature, self-clearing, uv under it does not trip
    @(negedge clk);
    over_temp = 1; rail_uv = 4'b0010;
    #1;
    chk("R5 shutdown on over_temp", shutdown, 1'b1);
    chk("R10 pwr_good on over_temp", pwr_good, 1'b0);
    edges(3 * T);
    over_temp = 0; rail_uv = '0;
    #1;
    chk("R5 returns after over_temp", shutdown, 1'b0);
    edges(5);
    chk("R5 no latch from over_temp", shutdown, 1'b0);

    // R6: each input lockout
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (k == 0) stby_low = 1; else main12_low = 1;
      rail_uv = 4'b1111;
      #1;
      chk("R6 shutdown on lockout", shutdown, 1'b1);
      edges(3 * T);
      stby_low = 0; main12_low = 0; rail_uv = '0;
      #1;
      chk("R6 returns after lockout", shutdown, 1'b0);
      chk("R6 pwr_good back", pwr_good, 1'b1);
      edges(4);
      chk("R6 no trip under lockout", shutdown, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule